// File: doc/BRIEF.md
# Linked-List Display Fetch Engine

This block pulls display data out of memory by following a chain of descriptors that software has placed in memory. Each descriptor occupies four consecutive 32-bit words: the address of the next descriptor, the start address of its payload, a frame identifier, and a command word. The engine reads those four words in one memory burst. It then reads the payload in bursts of at most sixteen words and places every word, with its tags, into an internal output FIFO. After that it moves to the descriptor that the next pointer names. A descriptor whose next pointer is its own address makes the engine fetch the same frame without end. Two descriptors that point at each other make it alternate between a colour-table load and a frame fetch.

Software writes a control register and two chain-start registers through a small write port. The engine has these states: `ST_IDLE`, `ST_DESC_REQ` (request the descriptor burst), `ST_DESC_WAIT` (collect the four words), `ST_PAY_REQ` (request a payload burst once the FIFO has room), `ST_PAY_WAIT` (collect payload beats) and `ST_NEXT` (advance the chain pointer). It moves between them as follows:
- IDLE to DESC_REQ when enable is set.
- DESC_REQ to DESC_WAIT when the request is accepted.
- DESC_WAIT to PAY_REQ on the fourth word if the length is non-zero, and to NEXT if it is zero.
- PAY_REQ to PAY_WAIT when the request is accepted.
- PAY_WAIT to PAY_REQ after the last beat of a burst while words remain, and to NEXT after the last word.
- NEXT to DESC_REQ while enabled, and to IDLE when enable is clear.

In split-panel mode two chains run side by side. The engine takes one descriptor from each chain in turn and marks every output word with the chain it came from.

Top module: `frame_desc_fetcher`

## Requirements
- R1: After reset, `mem_req` and `out_valid` are low, and they stay low until enable is written.
- R2: Each descriptor is read as one 4-word burst at the descriptor address. The words are taken in this order: next pointer, payload address, frame identifier, command.
- R3: Command bits [23:0] give the payload length in 32-bit words. A length of zero issues no payload read, and command bits 24 to 27 have no effect.
- R4: Payload reads are bursts of 16 words at byte addresses that rise by 64. When fewer than 16 words remain, the last burst asks for exactly the remainder. `mem_len` always lies between 1 and 16.
- R5: Every payload word leaves on `out_data` in memory order. `out_palette` on each word equals command bit 28 of its descriptor, and `out_frame_id` carries the descriptor's frame identifier.
- R6: Once a payload is complete, the next memory request is the descriptor at the stored next pointer. A self-pointing descriptor repeats, and two descriptors that point at each other alternate.
- R7: A payload request is raised only when the FIFO has room for the whole burst, so the FIFO never overflows. While `out_ready` is low, the output word stays unchanged.
- R8: If enable is cleared, the engine finishes the descriptor in progress and then issues no further requests. Setting enable again from idle restarts at the chain-0 start register.
- R9: The register map is: address 0 is control (bit 0 enable, bit 1 split-panel), address 1 is the chain-0 start and address 2 is the chain-1 start. In split-panel mode, descriptors are taken from chain 0 and chain 1 in turn, and `out_panel` gives the chain. In single mode the chain-1 start is ignored and `out_panel` is 0.
- R10: A memory request that has not been accepted keeps its address and length until `mem_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | 32 | Burst start byte address |
| mem_len | output | 5 | Burst length in words |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data beat valid |
| mem_rdata | input | 32 | Read data beat |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 32 | Payload word |
| out_frame_id | output | 32 | Frame identifier of the word's descriptor |
| out_palette | output | 1 | Word is colour-table data |
| out_panel | output | 1 | Chain the word came from |

## Verification
The engine is run on several chain shapes:
- A self-pointing 40-word descriptor, which separates full bursts from a shortened final burst.
- A colour-table and frame pair that point at each other, which shows whether the tag and the pointer follow are correct.
- A chain that includes a zero-length descriptor whose upper command bits are set, which shows whether the length field is masked and whether the payload phase is skipped.
- Two chains in split-panel mode, which shows the interleave order and the panel tag.

A 48-word frame drained by a consumer that is almost never ready tests the FIFO-room stall. Each run ends by clearing enable, which tests the stop at the descriptor boundary and the restart from a new start address.

// File: rtl/fdf_pkg.sv
package fdf_pkg;

    localparam int DESC_WORDS = 4;
    localparam int PAL_BIT    = 28;

    localparam logic [1:0] REG_CTRL   = 2'd0;
    localparam logic [1:0] REG_START0 = 2'd1;
    localparam logic [1:0] REG_START1 = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC_REQ,
        ST_DESC_WAIT,
        ST_PAY_REQ,
        ST_PAY_WAIT,
        ST_NEXT
    } fdf_state_t;

    typedef struct packed {
        logic        panel;
        logic        pal;
        logic [31:0] id;
        logic [31:0] data;
    } fdf_beat_t;

endpackage

// File: rtl/fdf_regs.sv
module fdf_regs
    import fdf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic        enable,
    output logic        dual,
    output logic [31:0] start0,
    output logic [31:0] start1
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable <= 1'b0;
            dual   <= 1'b0;
            start0 <= '0;
            start1 <= '0;
        end else if (we) begin
            unique case (addr)
                REG_CTRL: begin
                    enable <= wdata[0];
                    dual   <= wdata[1];
                end
                REG_START0: start0 <= wdata;
                REG_START1: start1 <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fdf_fifo.sv
module fdf_fifo #(
    parameter int WIDTH = 66,
    parameter int DEPTH = 32,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic [CW-1:0]    room
);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) store[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    assign dout  = store[rp];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign room  = CW'(DEPTH) - count;

endmodule

// File: rtl/fdf_engine.sv
module fdf_engine
    import fdf_pkg::*;
#(
    parameter int BURST  = 16,
    parameter int LEN_W  = 24,
    parameter int ROOM_W = 6,
    localparam int BL_W  = $clog2(BURST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              dual,
    input  logic [31:0]       start0,
    input  logic [31:0]       start1,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    output logic [BL_W-1:0]   mem_len,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic [ROOM_W-1:0] fifo_room,
    output logic              push,
    output fdf_beat_t         push_beat,
    output logic              idle,
    output logic              pay_req
);

    fdf_state_t        state_q, state_d;
    logic [31:0]       ptr0, ptr1, nxt_q, src_q, fid_q;
    logic              chain_q, dual_q, pal_q;
    logic [1:0]        beat_cnt;
    logic [LEN_W-1:0]  rem_q;
    logic [BL_W-1:0]   burst_left;
    logic [BL_W-1:0]   burst_len;
    logic [31:0]       cur_ptr;
    logic              room_ok;

    assign cur_ptr   = chain_q ? ptr1 : ptr0;
    assign burst_len = (rem_q >= LEN_W'(BURST)) ? BL_W'(BURST) : BL_W'(rem_q);
    assign room_ok   = (32'(fifo_room) >= 32'(burst_len));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        mem_req  = 1'b0;
        mem_addr = cur_ptr;
        mem_len  = BL_W'(DESC_WORDS);
        push     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) state_d = ST_DESC_REQ;
            end
            ST_DESC_REQ: begin
                mem_req = 1'b1;
                if (mem_ready) state_d = ST_DESC_WAIT;
            end
            ST_DESC_WAIT: begin
                if (mem_rvalid && beat_cnt == 2'd3)
                    state_d = (mem_rdata[LEN_W-1:0] == '0) ? ST_NEXT : ST_PAY_REQ;
            end
            ST_PAY_REQ: begin
                mem_addr = src_q;
                mem_len  = burst_len;
                mem_req  = room_ok;
                if (room_ok && mem_ready) state_d = ST_PAY_WAIT;
            end
            ST_PAY_WAIT: begin
                push = mem_rvalid;
                if (mem_rvalid && burst_left == BL_W'(1))
                    state_d = (rem_q == LEN_W'(1)) ? ST_NEXT : ST_PAY_REQ;
            end
            ST_NEXT: begin
                state_d = enable ? ST_DESC_REQ : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign push_beat = '{panel: chain_q, pal: pal_q, id: fid_q, data: mem_rdata};
    assign idle      = (state_q == ST_IDLE);
    assign pay_req   = (state_q == ST_PAY_REQ);

    // descriptor and chain datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr0       <= '0;
            ptr1       <= '0;
            nxt_q      <= '0;
            src_q      <= '0;
            fid_q      <= '0;
            chain_q    <= 1'b0;
            dual_q     <= 1'b0;
            pal_q      <= 1'b0;
            beat_cnt   <= '0;
            rem_q      <= '0;
            burst_left <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (enable) begin
                        ptr0    <= start0;
                        ptr1    <= start1;
                        chain_q <= 1'b0;
                        dual_q  <= dual;
                    end
                end
                ST_DESC_REQ: begin
                    if (mem_ready) beat_cnt <= '0;
                end
                ST_DESC_WAIT: begin
                    if (mem_rvalid) begin
                        beat_cnt <= beat_cnt + 1'b1;
                        unique case (beat_cnt)
                            2'd0: nxt_q <= mem_rdata;
                            2'd1: src_q <= mem_rdata;
                            2'd2: fid_q <= mem_rdata;
                            default: begin
                                rem_q <= mem_rdata[LEN_W-1:0];
                                pal_q <= mem_rdata[PAL_BIT];
                            end
                        endcase
                    end
                end
                ST_PAY_REQ: begin
                    if (room_ok && mem_ready) begin
                        src_q      <= src_q + (32'(burst_len) << 2);
                        burst_left <= burst_len;
                    end
                end
                ST_PAY_WAIT: begin
                    if (mem_rvalid) begin
                        burst_left <= burst_left - 1'b1;
                        rem_q      <= rem_q - 1'b1;
                    end
                end
                ST_NEXT: begin
                    if (chain_q) ptr1 <= nxt_q;
                    else         ptr0 <= nxt_q;
                    if (dual_q) chain_q <= ~chain_q;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/frame_desc_fetcher.sv
module frame_desc_fetcher
    import fdf_pkg::*;
#(
    parameter int BURST_WORDS = 16,
    parameter int FIFO_DEPTH  = 32,
    parameter int LEN_W       = 24,
    localparam int BL_W   = $clog2(BURST_WORDS + 1),
    localparam int ROOM_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_addr,
    input  logic [31:0]     cfg_wdata,
    output logic            mem_req,
    output logic [31:0]     mem_addr,
    output logic [BL_W-1:0] mem_len,
    input  logic            mem_ready,
    input  logic            mem_rvalid,
    input  logic [31:0]     mem_rdata,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [31:0]     out_data,
    output logic [31:0]     out_frame_id,
    output logic            out_palette,
    output logic            out_panel
);

    logic              enable, dual;
    logic [31:0]       start0, start1;
    logic              fifo_push, fifo_full, fifo_empty;
    logic [ROOM_W-1:0] fifo_room;
    fdf_beat_t         push_beat, head;
    logic              eng_idle, eng_pay_req;

    fdf_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .enable (enable),
        .dual   (dual),
        .start0 (start0),
        .start1 (start1)
    );

    fdf_engine #(
        .BURST  (BURST_WORDS),
        .LEN_W  (LEN_W),
        .ROOM_W (ROOM_W)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .dual       (dual),
        .start0     (start0),
        .start1     (start1),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_len    (mem_len),
        .mem_ready  (mem_ready),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .fifo_room  (fifo_room),
        .push       (fifo_push),
        .push_beat  (push_beat),
        .idle       (eng_idle),
        .pay_req    (eng_pay_req)
    );

    fdf_fifo #(
        .WIDTH ($bits(fdf_beat_t)),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .din   (push_beat),
        .pop   (out_valid && out_ready),
        .dout  (head),
        .empty (fifo_empty),
        .full  (fifo_full),
        .room  (fifo_room)
    );

    assign out_valid    = !fifo_empty;
    assign out_data     = head.data;
    assign out_frame_id = head.id;
    assign out_palette  = head.pal;
    assign out_panel    = head.panel;

endmodule

// File: rtl/fdf_checker.sv
module fdf_checker #(
    parameter int BURST  = 16,
    parameter int BL_W   = 5,
    parameter int ROOM_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_req,
    input  logic              mem_ready,
    input  logic [31:0]       mem_addr,
    input  logic [BL_W-1:0]   mem_len,
    input  logic              out_valid,
    input  logic              out_ready,
    input  logic [31:0]       out_data,
    input  logic              out_palette,
    input  logic              fifo_push,
    input  logic              fifo_full,
    input  logic [ROOM_W-1:0] fifo_room,
    input  logic              eng_idle,
    input  logic              eng_pay_req
);

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_len)); // R10

    AST_BURST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_len != '0) && (32'(mem_len) <= BURST)); // R4

    AST_ROOM_FOR_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        eng_pay_req && mem_req |-> 32'(fifo_room) >= 32'(mem_len)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        eng_idle |-> !mem_req); // R8

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_palette)); // R7

endmodule

bind frame_desc_fetcher fdf_checker #(
    .BURST  (BURST_WORDS),
    .BL_W   (BL_W),
    .ROOM_W (ROOM_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_ready   (mem_ready),
    .mem_addr    (mem_addr),
    .mem_len     (mem_len),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_palette (out_palette),
    .fifo_push   (fifo_push),
    .fifo_full   (fifo_full),
    .fifo_room   (fifo_room),
    .eng_idle    (eng_idle),
    .eng_pay_req (eng_pay_req)
);

// File: tb/frame_desc_fetcher_tb.sv
module frame_desc_fetcher_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [4:0]  mem_len;
    logic        mem_ready = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic [31:0] out_frame_id;
    logic        out_palette;
    logic        out_panel;

    frame_desc_fetcher u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .mem_len      (mem_len),
        .mem_ready    (mem_ready),
        .mem_rvalid   (mem_rvalid),
        .mem_rdata    (mem_rdata),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_data     (out_data),
        .out_frame_id (out_frame_id),
        .out_palette  (out_palette),
        .out_panel    (out_panel)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [31:0] mem [1024];
    logic [38:0] exp_req [$];   // {is_desc, addr, len6}
    logic [65:0] exp_out [$];   // {panel, pal, id, data}
    logic [32:0] beat_q  [$];   // {is_payload, data}
    int vectors = 0;
    int miscompares = 0;
    int desc_seen = 0;
    int occ = 0;
    int rdy_mode = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input logic [65:0] act, input logic [65:0] expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    // Reference model: walks the descriptor chain behaviourally.
    task automatic build(input logic [31:0] s0, input logic [31:0] s1, input bit dual, input int k);
        logic [31:0] p [2];
        int c;
        p[0] = s0;
        p[1] = s1;
        c = 0;
        for (int i = 0; i < k; i++) begin
            logic [31:0] d, nx, sa, id, cm;
            int rem;
            d  = p[c];
            nx = mem[d[11:2]];
            sa = mem[d[11:2] + 10'd1];
            id = mem[d[11:2] + 10'd2];
            cm = mem[d[11:2] + 10'd3];
            exp_req.push_back({1'b1, d, 6'd4});                     // R2
            rem = int'(cm[23:0]);                                    // R3
            while (rem > 0) begin
                int b;
                b = (rem > 16) ? 16 : rem;                           // R4
                exp_req.push_back({1'b0, sa, 6'(b)});
                for (int j = 0; j < b; j++)
                    exp_out.push_back({c[0], cm[28], id, mem[sa[11:2] + 10'(j)]}); // R5
                sa  = sa + 32'(b * 4);
                rem = rem - b;
            end
            p[c] = nx;                                               // R6
            if (dual) c = c ^ 1;                                     // R9
        end
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] nx, input logic [31:0] sa,
                            input logic [31:0] id, input logic [31:0] cm);
        mem[a[11:2]]         = nx;
        mem[a[11:2] + 10'd1] = sa;
        mem[a[11:2] + 10'd2] = id;
        mem[a[11:2] + 10'd3] = cm;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk);
        #1;
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    // Compare at every falling edge against the model queues.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !finished) begin
                if (mem_req && mem_ready) begin
                    logic [38:0] e;
                    if (exp_req.size() == 0) begin
                        check(1'b0, "R8 unexpected request", {33'd0, mem_addr, 1'b0}, '0);
                    end else begin
                        e = exp_req.pop_front();
                        check({mem_addr, 6'(mem_len)} == e[37:0], e[38] ? "R2 descriptor request" : "R4 payload request",
                              {28'd0, mem_addr, 6'(mem_len)}, {28'd0, e[37:0]});
                        if (e[38]) desc_seen++;
                        for (int j = 0; j < int'(mem_len); j++)
                            beat_q.push_back({!e[38], mem[mem_addr[11:2] + 10'(j)]});
                    end
                end
                if (out_valid && out_ready) begin
                    logic [65:0] o;
                    if (exp_out.size() == 0) begin
                        check(1'b0, "R5 unexpected output", {out_panel, out_palette, out_frame_id, out_data}, '0);
                    end else begin
                        o = exp_out.pop_front();
                        check({out_panel, out_palette, out_frame_id, out_data} == o, "R5 output word",
                              {out_panel, out_palette, out_frame_id, out_data}, o);
                    end
                    occ--;
                end
                if (occ > DEPTH) check(1'b0, "R7 FIFO occupancy", 66'(occ), 66'(DEPTH));
            end
        end
    end

    // Memory responder and consumer drive, just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            mem_ready = ($urandom_range(2) != 0);
            out_ready = (rdy_mode == 0) ? 1'b1 : ($urandom_range(9) == 0);
            if (beat_q.size() > 0 && $urandom_range(3) != 0) begin
                logic [32:0] b;
                b = beat_q.pop_front();
                mem_rvalid = 1'b1;
                mem_rdata  = b[31:0];
                if (b[32]) occ++;
            end else begin
                mem_rvalid = 1'b0;
                mem_rdata  = '0;
            end
        end
    end

    task automatic run_case(input logic [31:0] s0, input logic [31:0] s1, input bit dual, input int k,
                            input int rmode, input string tag);
        build(s0, s1, dual, k);
        rdy_mode  = rmode;
        desc_seen = 0;
        wr(2'd1, s0);
        wr(2'd2, s1);
        wr(2'd0, {30'd0, dual, 1'b1});
        while (desc_seen < k) @(negedge clk);
        wr(2'd0, {30'd0, dual, 1'b0});                               // R8 stop request
        while (exp_req.size() != 0 || exp_out.size() != 0) @(negedge clk);
        repeat (30) @(negedge clk);
        check(exp_req.size() == 0 && exp_out.size() == 0, tag, 66'(exp_req.size()), '0);
        check(!mem_req && !out_valid, "R8 quiet after stop", {64'd0, mem_req, out_valid}, '0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'(i) * 32'h9E37_79B1 + 32'h0000_5A5A;
        put_desc(32'h000, 32'h000, 32'h400, 32'h11, 32'd40);                    // self loop
        put_desc(32'h010, 32'h020, 32'h800, 32'h22, 32'h1000_0000 | 32'd20);    // colour table
        put_desc(32'h020, 32'h010, 32'h900, 32'h33, 32'd16);                    // frame
        put_desc(32'h030, 32'h040, 32'hA00, 32'h44, 32'h0F00_0000);             // zero length
        put_desc(32'h040, 32'h030, 32'hA00, 32'h55, 32'd5);
        put_desc(32'h050, 32'h050, 32'hB00, 32'h66, 32'd48);
        put_desc(32'h060, 32'h070, 32'hC00, 32'h77, 32'd33);
        put_desc(32'h070, 32'h060, 32'hD00, 32'h88, 32'h1000_0000 | 32'd3);

        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!mem_req, "R1 reset request", {65'd0, mem_req}, '0);
        check(!out_valid, "R1 reset output", {65'd0, out_valid}, '0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check(!mem_req && !out_valid, "R1 idle before enable", {64'd0, mem_req, out_valid}, '0);

        run_case(32'h000, 32'h050, 1'b0, 3, 0, "R6 self loop, R9 single ignores chain 1");
        run_case(32'h010, 32'h000, 1'b0, 4, 0, "R6 alternation, R5 tag");
        run_case(32'h030, 32'h000, 1'b0, 3, 0, "R3 zero length");
        run_case(32'h050, 32'h000, 1'b0, 2, 1, "R7 backpressure");
        run_case(32'h000, 32'h060, 1'b1, 5, 0, "R9 split panel");
        run_case(32'h020, 32'h000, 1'b0, 2, 0, "R8 restart at new start");

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", '0, '0);
        summary();
        $finish;
    end

endmodule